// File: doc/BRIEF.md
# 1-Wire Slave ROM Function Layer

This block is the addressing layer of a 1-Wire slave. It sits above a bit-slot engine that detects bus resets, delivers each bit the master writes, and tells the block when the master opens a read slot. After every bus reset the block gathers an 8-bit command, least significant bit first, and carries out the addressing step that command names. It then either hands the bus to the memory-function layer by raising `selected_o`, or drops out and ignores the bus until the next reset.

The 64-bit identity is built from two parameters, an 8-bit family code and a 48-bit serial number. The block computes the 8-bit check byte over those 56 bits while it elaborates. The block keeps the overdrive-speed flag, which the slot engine uses to pick its slot timing. It also keeps the resume flag, which lets the master select the last addressed device again without sending its identity.

Top module: `ow_rom_layer`

## Requirements
- R1: After `rst`, `selected_o`, `overdrive_o` and `resume_o` are 0 and `tx_bit_o` is 1. Until the first `bus_reset_i`, all received bits are ignored.
- R2: A `bus_reset_i` pulse aborts whatever is in progress. `selected_o` is 0 in the following cycle, and the next 8 received bits are taken as a new command byte.
- R3: A bus reset with `reset_std_i`=1 (standard-speed length) clears `overdrive_o`. With `reset_std_i`=0 the flag is kept.
- R4: Command 55h followed by 64 bits equal to the identity sets `selected_o` and `resume_o`. Issuing 55h clears `resume_o`.
- R5: In a 55h match, a bit that differs from the identity at any position leaves `selected_o` at 0 until the next bus reset, whatever bits follow.
- R6: Command CCh sets `selected_o` and clears `resume_o`.
- R7: For command F0h, for each identity bit in turn the block answers two read slots on `tx_bit_o`, first with the bit and then with its inverse. It then takes one direction bit. An equal direction bit continues the search; after 64 bits the block selects and sets `resume_o`. An unequal direction bit drops out with `tx_bit_o` held at 1.
- R8: Command 3Ch sets `selected_o` and `overdrive_o` and clears `resume_o`.
- R9: Command 69h sets `overdrive_o` as soon as its eighth bit arrives, then matches 64 bits as in R4. On a mismatch `overdrive_o` returns to the value it had before the command.
- R10: Command A5h sets `selected_o` when `resume_o` is 1, and otherwise drops out.
- R11: Any command byte other than 55h, CCh, F0h, 3Ch, 69h and A5h drops out. `selected_o` and `overdrive_o` stay unchanged until the next bus reset.
- R12: Identity bit 0 is the family-code LSB. Bits 55:8 hold the serial number and bits 63:56 hold the CRC-8 (polynomial x^8+x^5+x^4+1, reflected, initial 0) of bits 55:0. Bits are sent and compared starting from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: reset pulse seen on the bus |
| reset_std_i | input | 1 | Qualifies `bus_reset_i`: 1 = standard-length reset |
| rx_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| rd_slot_i | input | 1 | One-cycle pulse: a read slot consumed `tx_bit_o` |
| tx_bit_o | output | 1 | Bit to return in the next read slot (1 = release) |
| selected_o | output | 1 | Device selected for the memory-function layer |
| overdrive_o | output | 1 | Overdrive-speed flag |
| resume_o | output | 1 | Resume flag |

## Verification
The match path is swept by flipping each of the 64 identity positions in turn. This separates a comparison that checks every bit from one that checks only some of them, and it exposes a bit order that is off by one. The search path is swept the same way: every position is tried as the drop-out point, and a full search reads out the identity, whose expected check byte comes from a known value. All 256 command bytes are tried, so the six valid codes are set apart from every other byte. The overdrive and resume flags are checked across reset lengths and across prior flag states.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CRC_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int ID_W   = BODY_W + CRC_W;
  localparam int CMD_W  = 8;

  localparam logic [CMD_W-1:0] OPC_MATCH    = 8'h55;
  localparam logic [CMD_W-1:0] OPC_SKIP     = 8'hCC;
  localparam logic [CMD_W-1:0] OPC_SEARCH   = 8'hF0;
  localparam logic [CMD_W-1:0] OPC_RESUME   = 8'hA5;
  localparam logic [CMD_W-1:0] OPC_OD_SKIP  = 8'h3C;
  localparam logic [CMD_W-1:0] OPC_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    RC_MATCH, RC_SKIP, RC_SEARCH, RC_RESUME, RC_OD_SKIP, RC_OD_MATCH, RC_OTHER
  } rom_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_CMD, ST_MATCH, ST_SEARCH, ST_SEL
  } rom_st_e;

  // reflected CRC-8, polynomial x^8+x^5+x^4+1, initial value 0
  function automatic logic [CRC_W-1:0] crc8_id(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/ow_rom_decode.sv
module ow_rom_decode
  import ow_rom_pkg::*;
(
  input  logic [CMD_W-1:0] byte_i,
  output rom_cmd_e         cmd_o
);
  always_comb begin
    unique case (byte_i)
      OPC_MATCH:    cmd_o = RC_MATCH;
      OPC_SKIP:     cmd_o = RC_SKIP;
      OPC_SEARCH:   cmd_o = RC_SEARCH;
      OPC_RESUME:   cmd_o = RC_RESUME;
      OPC_OD_SKIP:  cmd_o = RC_OD_SKIP;
      OPC_OD_MATCH: cmd_o = RC_OD_MATCH;
      default:      cmd_o = RC_OTHER;
    endcase
  end
endmodule

// File: rtl/ow_rom_bitpick.sv
module ow_rom_bitpick #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);
  assign bit_o = vec_i[idx_i];
endmodule

// File: rtl/ow_rom_speed.sv
module ow_rom_speed (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,      // standard-length bus reset
  input  logic set_i,      // overdrive skip
  input  logic save_i,     // overdrive match: remember old value, then set
  input  logic restore_i,  // overdrive match failed
  output logic od_o
);
  logic shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      od_o     <= 1'b0;
      shadow_q <= 1'b0;
    end else if (clr_i) begin
      od_o <= 1'b0;
    end else if (restore_i) begin
      od_o <= shadow_q;
    end else if (save_i) begin
      shadow_q <= od_o;
      od_o     <= 1'b1;
    end else if (set_i) begin
      od_o <= 1'b1;
    end
  end

  AST_STD_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> !od_o); // R3

endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
  import ow_rom_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h02,
  parameter logic [SER_W-1:0] SERIAL = 48'h00000001B81C
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic reset_std_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic rd_slot_i,
  output logic tx_bit_o,
  output logic selected_o,
  output logic overdrive_o,
  output logic resume_o
);
  localparam logic [ID_W-1:0] ID_VEC = {crc8_id({SERIAL, FAMILY}), SERIAL, FAMILY};
  localparam int CW = $clog2(ID_W);
  localparam logic [CW-1:0] CMD_LAST = CW'(CMD_W - 1);
  localparam logic [CW-1:0] ID_LAST  = CW'(ID_W - 1);
  localparam logic [1:0] PH_TRUE = 2'd0;
  localparam logic [1:0] PH_CPL  = 2'd1;
  localparam logic [1:0] PH_DIR  = 2'd2;

  rom_st_e          state_q, nxt_state;
  logic [CW-1:0]    cnt_q, nxt_cnt;
  logic [1:0]       ph_q, nxt_ph;
  logic [CMD_W-2:0] sr_q, nxt_sr;
  logic             om_q, nxt_om;
  logic             res_q, nxt_res;
  logic             sel_q, tx_q;
  logic             od_set, od_save, od_restore;
  logic             cur_bit, nxt_bit;
  rom_cmd_e         cmd;

  ow_rom_decode u_dec (
    .byte_i ({rx_bit_i, sr_q}),
    .cmd_o  (cmd)
  );

  ow_rom_bitpick #(.W(ID_W)) u_pick_cur (
    .vec_i (ID_VEC),
    .idx_i (cnt_q),
    .bit_o (cur_bit)
  );

  ow_rom_bitpick #(.W(ID_W)) u_pick_nxt (
    .vec_i (ID_VEC),
    .idx_i (nxt_cnt),
    .bit_o (nxt_bit)
  );

  ow_rom_speed u_speed (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (bus_reset_i & reset_std_i),
    .set_i     (od_set),
    .save_i    (od_save),
    .restore_i (od_restore),
    .od_o      (overdrive_o)
  );

  always_comb begin
    nxt_state  = state_q;
    nxt_cnt    = cnt_q;
    nxt_ph     = ph_q;
    nxt_sr     = sr_q;
    nxt_om     = om_q;
    nxt_res    = res_q;
    od_set     = 1'b0;
    od_save    = 1'b0;
    od_restore = 1'b0;
    if (bus_reset_i) begin
      nxt_state = ST_CMD;
      nxt_cnt   = '0;
      nxt_ph    = PH_TRUE;
      nxt_sr    = '0;
      nxt_om    = 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_valid_i) begin
          nxt_sr = {rx_bit_i, sr_q[CMD_W-2:1]};
          if (cnt_q == CMD_LAST) begin
            nxt_cnt = '0;
            unique case (cmd)
              RC_MATCH:    begin nxt_state = ST_MATCH;  nxt_res = 1'b0; end
              RC_SKIP:     begin nxt_state = ST_SEL;    nxt_res = 1'b0; end
              RC_SEARCH:   begin nxt_state = ST_SEARCH; nxt_res = 1'b0; nxt_ph = PH_TRUE; end
              RC_RESUME:   nxt_state = res_q ? ST_SEL : ST_WAIT;
              RC_OD_SKIP:  begin nxt_state = ST_SEL;    nxt_res = 1'b0; od_set = 1'b1; end
              RC_OD_MATCH: begin
                nxt_state = ST_MATCH;
                nxt_res   = 1'b0;
                nxt_om    = 1'b1;
                od_save   = 1'b1;
              end
              default:     nxt_state = ST_WAIT;
            endcase
          end else begin
            nxt_cnt = cnt_q + 1'b1;
          end
        end
        ST_MATCH: if (rx_valid_i) begin
          if (rx_bit_i != cur_bit) begin
            nxt_state  = ST_WAIT;
            od_restore = om_q;
          end else if (cnt_q == ID_LAST) begin
            nxt_state = ST_SEL;
            nxt_res   = 1'b1;
          end else begin
            nxt_cnt = cnt_q + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (ph_q != PH_DIR) begin
            if (rd_slot_i) nxt_ph = ph_q + 1'b1;
          end else if (rx_valid_i) begin
            if (rx_bit_i != cur_bit) begin
              nxt_state = ST_WAIT;
            end else if (cnt_q == ID_LAST) begin
              nxt_state = ST_SEL;
              nxt_res   = 1'b1;
            end else begin
              nxt_cnt = cnt_q + 1'b1;
              nxt_ph  = PH_TRUE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      ph_q    <= PH_TRUE;
      sr_q    <= '0;
      om_q    <= 1'b0;
      res_q   <= 1'b0;
      sel_q   <= 1'b0;
      tx_q    <= 1'b1;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= nxt_cnt;
      ph_q    <= nxt_ph;
      sr_q    <= nxt_sr;
      om_q    <= nxt_om;
      res_q   <= nxt_res;
      sel_q   <= (nxt_state == ST_SEL);
      tx_q    <= (nxt_state == ST_SEARCH && nxt_ph != PH_DIR)
                 ? (nxt_bit ^ (nxt_ph == PH_CPL)) : 1'b1;
    end
  end

  assign tx_bit_o   = tx_q;
  assign selected_o = sel_q;
  assign resume_o   = res_q;

  AST_DESELECT_ON_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(bus_reset_i) |-> !selected_o); // R2
  AST_SEL_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(selected_o) |-> ($past(rx_valid_i) && !$past(bus_reset_i))); // R4
  AST_TX_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SEARCH) |-> tx_bit_o); // R7
  AST_SEARCH_CPL: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEARCH && ph_q == PH_CPL && $past(ph_q) == PH_TRUE)
      |-> (tx_bit_o != $past(tx_bit_o))); // R7
  AST_OD_RISE_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(overdrive_o) |-> $past(rx_valid_i)); // R8
  AST_RESUME_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_o) |-> selected_o); // R10

endmodule

// File: tb/ow_rom_layer_test.sv
module ow_rom_layer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] EXP_ID = 64'hA200000001B81C02;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset_i = 1'b0, reset_std_i = 1'b0;
  logic rx_valid_i = 1'b0, rx_bit_i = 1'b0, rd_slot_i = 1'b0;
  logic tx_bit_o, selected_o, overdrive_o, resume_o;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ow_rom_layer uut (
    .clk, .rst, .bus_reset_i, .reset_std_i, .rx_valid_i, .rx_bit_i,
    .rd_slot_i, .tx_bit_o, .selected_o, .overdrive_o, .resume_o
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic bus_rst(input logic std);
    @(negedge clk); bus_reset_i = 1'b1; reset_std_i = std;
    @(negedge clk); bus_reset_i = 1'b0; reset_std_i = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_valid_i = 1'b1; rx_bit_i = b;
    @(negedge clk); rx_valid_i = 1'b0; rx_bit_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_id(input int flip);
    for (int i = 0; i < 64; i++) send_bit(EXP_ID[i] ^ (i == flip));
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); b = tx_bit_o; rd_slot_i = 1'b1;
    @(negedge clk); rd_slot_i = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic b, c;
    logic [63:0] got_id;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, bits ignored before first bus reset
    chk("R1 sel", selected_o, 1'b0);
    chk("R1 od", overdrive_o, 1'b0);
    chk("R1 res", resume_o, 1'b0);
    chk("R1 tx", tx_bit_o, 1'b1);
    send_byte(8'hCC);
    chk("R1 no cmd before reset", selected_o, 1'b0);

    // R6 skip
    bus_rst(1'b1); send_byte(8'hCC);
    chk("R6 sel", selected_o, 1'b1);
    chk("R6 res", resume_o, 1'b0);

    // R4 match
    bus_rst(1'b1);
    chk("R2 deselect", selected_o, 1'b0);
    send_byte(8'h55);
    for (int i = 0; i < 63; i++) send_bit(EXP_ID[i]);
    chk("R4 not before last bit", selected_o, 1'b0);
    send_bit(EXP_ID[63]);
    chk("R4 sel", selected_o, 1'b1);
    chk("R4 res", resume_o, 1'b1);

    // R5 mismatch at each position
    for (int k = 0; k < 64; k++) begin
      bus_rst(1'b1); send_byte(8'h55); send_id(k);
      chk($sformatf("R5 bit %0d sel", k), selected_o, 1'b0);
      chk("R4 res cleared", resume_o, 1'b0);
    end

    // R10 resume
    bus_rst(1'b1); send_byte(8'hA5);
    chk("R10 no flag", selected_o, 1'b0);
    bus_rst(1'b1); send_byte(8'h55); send_id(-1);
    bus_rst(1'b1); send_byte(8'hA5);
    chk("R10 flag set", selected_o, 1'b1);

    // R7/R12 full search
    bus_rst(1'b1); send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(b); read_bit(c);
      got_id[i] = b;
      chk("R7 complement", c, ~b);
      send_bit(b);
    end
    chk("R12 identity", got_id == EXP_ID, 1'b1);
    chk("R7 sel", selected_o, 1'b1);
    chk("R7 res", resume_o, 1'b1);

    // R7 drop out at each position
    for (int k = 0; k < 64; k++) begin
      bus_rst(1'b1); send_byte(8'hF0);
      for (int i = 0; i < k; i++) begin
        read_bit(b); read_bit(c); send_bit(b);
      end
      read_bit(b); read_bit(c);
      chk("R12 bit order", b, EXP_ID[k]);
      send_bit(~b);
      read_bit(b);
      chk($sformatf("R7 drop %0d tx", k), b, 1'b1);
      chk("R7 drop sel", selected_o, 1'b0);
    end

    // R8 / R3
    bus_rst(1'b1); send_byte(8'h3C);
    chk("R8 sel", selected_o, 1'b1);
    chk("R8 od", overdrive_o, 1'b1);
    chk("R8 res", resume_o, 1'b0);
    bus_rst(1'b0);
    chk("R3 short keeps od", overdrive_o, 1'b1);
    chk("R2 sel cleared", selected_o, 1'b0);
    bus_rst(1'b1);
    chk("R3 std clears od", overdrive_o, 1'b0);

    // R9 overdrive match from standard speed
    bus_rst(1'b1); send_byte(8'h69);
    chk("R9 od early", overdrive_o, 1'b1);
    send_id(17);
    chk("R9 fail od back", overdrive_o, 1'b0);
    chk("R9 fail sel", selected_o, 1'b0);
    bus_rst(1'b1); send_byte(8'h69); send_id(-1);
    chk("R9 ok sel", selected_o, 1'b1);
    chk("R9 ok od", overdrive_o, 1'b1);
    // R9 already overdrive
    bus_rst(1'b1); send_byte(8'h3C); bus_rst(1'b0);
    send_byte(8'h69); send_id(40);
    chk("R9 kept od", overdrive_o, 1'b1);
    bus_rst(1'b1);

    // R11 every other command byte
    for (int v = 0; v < 256; v++) begin
      if (v == 8'h55 || v == 8'hCC || v == 8'hF0 || v == 8'h3C ||
          v == 8'h69 || v == 8'hA5) continue;
      bus_rst(1'b1); send_byte(8'(v)); send_byte(8'hCC);
      chk($sformatf("R11 %02h sel", v), selected_o, 1'b0);
      chk("R11 od", overdrive_o, 1'b0);
      chk("R11 tx", tx_bit_o, 1'b1);
    end

    // R2 abort mid-match
    bus_rst(1'b1); send_byte(8'h55);
    for (int i = 0; i < 30; i++) send_bit(EXP_ID[i]);
    bus_rst(1'b0); send_byte(8'hCC);
    chk("R2 abort then skip", selected_o, 1'b1);

    summary();
  end
endmodule